// File: doc/BRIEF.md
# ADC Regular Scan Sequencer

This block drives an external analog-to-digital converter through a programmable list of up to sixteen conversions. Software fills a set of slot fields with channel numbers, sets a sequence length, switches the block on and sets a software start bit. The sequencer then requests one conversion per slot, beginning with the first slot. It stores each result, right-aligned to the chosen resolution, in a 16-bit data register.

The converter is abstract. The sequencer raises a one-cycle start pulse together with a channel number. The converter later returns a one-cycle done pulse with a 12-bit raw code. Every stored result sets an end-of-conversion flag, which can drive an interrupt line. A result can also raise a one-cycle DMA request. A flag that is still unread when a newer result arrives becomes an overrun.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq`, `dma_req` and `conv_start` are low.
- R2: Slots are converted in ascending order from slot 1. Slot k (counted from 0) is a 5-bit field. It sits in word k/6 at bit 5*(k%6). Word 0 (slots 1-6) is at address 5, word 1 (slots 7-12) at address 4, and word 2 (slots 13-16) at address 3.
- R3: The length field is bits 23:20 of address 3 and holds the conversion count minus one. When the scan bit (address 1, bit 8) is clear, only slot 1 is converted, whatever the length.
- R4: The resolution code (address 1, bits 25:24) values 0, 1, 2 and 3 give 12, 10, 8 and 6 bits. The data register (address 6) holds the raw code shifted right by twice the code.
- R5: Status (address 0) has end-of-conversion at bit 1, started at bit 4 and overrun at bit 5. End-of-conversion is set by each result and cleared by a read of the data register. Started is set when a conversion is issued. Writing 0 to a status bit clears it, and writing 1 has no effect.
- R6: `irq` is high exactly while end-of-conversion is set and the interrupt enable (address 1, bit 5) is set.
- R7: Control word 2 (address 2) holds power at bit 0, DMA enable at bit 8, continuous DMA at bit 9, trigger mode at bits 29:28 and software start at bit 30. A write with start=1 launches a sequence only if power=1 and trigger mode=0 in the same write; otherwise the start bit reads 0 and nothing happens. The start bit clears itself once the first conversion is accepted.
- R8: A result that arrives while end-of-conversion is still set (and not being read in that cycle) sets overrun, and the newer result replaces the data.
- R9: With DMA enabled, each result raises `dma_req` for one cycle, one cycle after `conv_done`. Without the continuous bit, requests stop after the last result of a sequence until DMA enable is written 0. With the continuous bit, requests continue across sequences.
- R10: Clearing power aborts the sequence. No `conv_start` follows, a `conv_done` arriving while idle is ignored, and the next start begins again at slot 1.
- R11: `conv_start` is a one-cycle pulse. No new pulse is issued until the converter has returned `conv_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read clears end-of-conversion) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 5 | Channel of the requested conversion |
| conv_done | input | 1 | Converter result valid pulse |
| conv_result | input | 12 | Raw converter code |
| irq | output | 1 | End-of-conversion interrupt |
| dma_req | output | 1 | One-cycle DMA request per result |

## Verification
The hardest case to reach is an abort in the middle of a sequence. Power must drop while a conversion is outstanding, and the converter's late done pulse must then be ignored. The bench's converter model has a hold switch that delays the done pulse indefinitely. The bench removes power while the first conversion is held, then releases the hold. It checks that no further start appears and that the status stays clear. It then checks that a fresh start begins again at slot 1. The DMA-halt corner is reached by running two back-to-back sequences without the continuous bit and counting requests.

// File: rtl/seq_pkg.sv
// Shared definitions for the scan sequencer: register word addresses,
// engine states and the bit positions software depends on.
package seq_pkg;
    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_CTRL_A = 3'd1,
        A_CTRL_B = 3'd2,
        A_SEQ2   = 3'd3,
        A_SEQ1   = 3'd4,
        A_SEQ0   = 3'd5,
        A_DATA   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT
    } eng_state_e;

    localparam int ST_EOC  = 1;
    localparam int ST_STRT = 4;
    localparam int ST_OVR  = 5;
    localparam int CA_IE   = 5;
    localparam int CA_SCAN = 8;
    localparam int CA_RES  = 24;
    localparam int CB_PWR  = 0;
    localparam int CB_DMA  = 8;
    localparam int CB_CONT = 9;
    localparam int CB_TRIG = 28;
    localparam int CB_SW   = 30;
    localparam int LEN_LSB = 20;
endpackage

// File: rtl/seq_slot_mux.sv
// Unpacks the slot channel fields from the packed sequence words and
// selects the one addressed by the current slot index.
// Assumes WORDS*PER_WORD >= NUM_SLOTS.
module seq_slot_mux #(
    parameter int NUM_SLOTS = 16,
    parameter int FIELD_W   = 5,
    parameter int PER_WORD  = 6,
    parameter int WORDS     = 3,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [WORDS*PER_WORD*FIELD_W-1:0] fields,
    input  logic [IDX_W-1:0]                  idx,
    output logic [FIELD_W-1:0]                chan
);
    logic [FIELD_W-1:0] slot_chan [NUM_SLOTS];

    // one field extractor per slot
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_chan[k] =
            fields[(k / PER_WORD) * PER_WORD * FIELD_W + (k % PER_WORD) * FIELD_W +: FIELD_W];
    end

    assign chan = slot_chan[idx];
endmodule

// File: rtl/seq_engine.sv
// Slot walker: on go, issues one conversion per slot and waits for each
// done pulse. It advances only while scan is enabled and the last index
// has not been reached. Loss of power returns it to idle at once.
module seq_engine #(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power,
    input  logic             go,
    input  logic             scan_en,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             conv_done,
    output logic             conv_start,
    output logic [IDX_W-1:0] slot_idx,
    output logic             accept,
    output logic             res_valid,
    output logic             seq_end
);
    import seq_pkg::*;

    eng_state_e state;

    assign accept     = (state == S_IDLE) && go && power;
    assign conv_start = (state == S_ISSUE) && power;
    assign res_valid  = (state == S_WAIT) && conv_done && power;
    assign seq_end    = res_valid && (!scan_en || slot_idx == last_idx);

    // state and slot index sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !power) begin
            state    <= S_IDLE;
            slot_idx <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    state    <= S_ISSUE;
                    slot_idx <= '0;
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (conv_done) begin
                    if (seq_end) state <= S_IDLE;
                    else begin
                        state    <= S_ISSUE;
                        slot_idx <= slot_idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R10
    no_start_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power |=> !conv_start);
endmodule

// File: rtl/scan_seq_ctrl.sv
// Register file and status logic of the scan sequencer. It holds the
// control words, the packed slot words and the data register, and it
// derives end-of-conversion, started, overrun, irq and DMA requests.
// Assumes single-cycle register strobes and a converter that answers
// every conv_start with one conv_done.
module scan_seq_ctrl #(
    parameter int NUM_SLOTS = 16,
    parameter int CH_W      = 5,
    parameter int RAW_W     = 12,
    parameter int PER_WORD  = 6,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int WORDS    = (NUM_SLOTS + PER_WORD - 1) / PER_WORD,
    localparam int WORD_W   = PER_WORD * CH_W,
    localparam int DATA_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RAW_W-1:0] conv_result,
    output logic             irq,
    output logic             dma_req
);
    import seq_pkg::*;

    logic              scan_q, ie_q;
    logic [1:0]        res_q;
    logic              pwr_q, dma_q, cont_q, swst_q;
    logic [1:0]        trig_q;
    logic [WORD_W-1:0] seq_q [WORDS];
    logic [DATA_W-1:0] data_q;
    logic              eoc_q, strt_q, ovr_q, dma_halt_q, dma_req_q;
    logic [WORDS*WORD_W-1:0] seq_flat;
    logic [IDX_W-1:0]  slot_idx, len_idx;
    logic              accept, res_valid, seq_end;
    logic              wr_a, wr_b, wr_st, data_rd;

    assign wr_a    = reg_wr && reg_addr == A_CTRL_A;
    assign wr_b    = reg_wr && reg_addr == A_CTRL_B;
    assign wr_st   = reg_wr && reg_addr == A_STATUS;
    assign data_rd = reg_rd && reg_addr == A_DATA;
    assign len_idx = seq_q[WORDS-1][LEN_LSB +: IDX_W];

    // flatten the slot words, word 0 lowest
    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign seq_flat[w*WORD_W +: WORD_W] = seq_q[w];
    end

    seq_slot_mux #(.NUM_SLOTS(NUM_SLOTS), .FIELD_W(CH_W), .PER_WORD(PER_WORD), .WORDS(WORDS))
        u_mux (.fields(seq_flat), .idx(slot_idx), .chan(conv_chan));

    seq_engine #(.NUM_SLOTS(NUM_SLOTS)) u_eng (
        .clk(clk), .rst_n(rst_n), .power(pwr_q), .go(swst_q), .scan_en(scan_q),
        .last_idx(len_idx), .conv_done(conv_done), .conv_start(conv_start),
        .slot_idx(slot_idx), .accept(accept), .res_valid(res_valid), .seq_end(seq_end));

    // control word and slot word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scan_q, ie_q, res_q} <= '0;
            {pwr_q, dma_q, cont_q, trig_q} <= '0;
            for (int w = 0; w < WORDS; w++) seq_q[w] <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL_A: begin
                    scan_q <= reg_wdata[CA_SCAN];
                    ie_q   <= reg_wdata[CA_IE];
                    res_q  <= reg_wdata[CA_RES +: 2];
                end
                A_CTRL_B: begin
                    pwr_q  <= reg_wdata[CB_PWR];
                    dma_q  <= reg_wdata[CB_DMA];
                    cont_q <= reg_wdata[CB_CONT];
                    trig_q <= reg_wdata[CB_TRIG +: 2];
                end
                A_SEQ0: seq_q[0] <= reg_wdata[WORD_W-1:0];
                A_SEQ1: seq_q[1] <= reg_wdata[WORD_W-1:0];
                A_SEQ2: seq_q[2] <= reg_wdata[WORD_W-1:0];
                default: ;
            endcase
        end
    end

    // pending software start: set by a qualified write, cleared on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) swst_q <= 1'b0;
        else if (wr_b)
            swst_q <= reg_wdata[CB_SW] && reg_wdata[CB_PWR] && reg_wdata[CB_TRIG +: 2] == 2'b00;
        else if (accept || !pwr_q) swst_q <= 1'b0;
    end

    // status flags and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {eoc_q, strt_q, ovr_q} <= '0;
            data_q <= '0;
        end else begin
            if (wr_st && !reg_wdata[ST_EOC]) eoc_q <= 1'b0;
            if (data_rd) eoc_q <= 1'b0;
            if (res_valid) eoc_q <= 1'b1;
            if (wr_st && !reg_wdata[ST_STRT]) strt_q <= 1'b0;
            if (conv_start) strt_q <= 1'b1;
            if (wr_st && !reg_wdata[ST_OVR]) ovr_q <= 1'b0;
            if (res_valid && eoc_q && !data_rd) ovr_q <= 1'b1;
            if (res_valid)
                data_q <= DATA_W'(conv_result) >> {res_q, 1'b0};
        end
    end

    // DMA request pulse and end-of-sequence halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req_q  <= 1'b0;
            dma_halt_q <= 1'b0;
        end else begin
            dma_req_q <= res_valid && dma_q && !dma_halt_q;
            if (wr_b && !reg_wdata[CB_DMA]) dma_halt_q <= 1'b0;
            else if (seq_end && dma_q && !cont_q) dma_halt_q <= 1'b1;
        end
    end

    assign irq     = eoc_q && ie_q;
    assign dma_req = dma_req_q;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: begin
                reg_rdata[ST_EOC]  = eoc_q;
                reg_rdata[ST_STRT] = strt_q;
                reg_rdata[ST_OVR]  = ovr_q;
            end
            A_CTRL_A: begin
                reg_rdata[CA_SCAN]     = scan_q;
                reg_rdata[CA_IE]       = ie_q;
                reg_rdata[CA_RES +: 2] = res_q;
            end
            A_CTRL_B: begin
                reg_rdata[CB_PWR]       = pwr_q;
                reg_rdata[CB_DMA]       = dma_q;
                reg_rdata[CB_CONT]      = cont_q;
                reg_rdata[CB_TRIG +: 2] = trig_q;
                reg_rdata[CB_SW]        = swst_q;
            end
            A_SEQ0:  reg_rdata[WORD_W-1:0] = seq_q[0];
            A_SEQ1:  reg_rdata[WORD_W-1:0] = seq_q[1];
            A_SEQ2:  reg_rdata[WORD_W-1:0] = seq_q[2];
            A_DATA:  reg_rdata[DATA_W-1:0] = data_q;
            default: reg_rdata = '0;
        endcase
    end

    // R5
    eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> eoc_q);
    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && eoc_q && !data_rd) |=> ovr_q);
    // R9
    dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(res_valid));
    // R7
    swst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_b) |=> !swst_q);
endmodule

// File: tb/scan_seq_ctrl_test.sv
module scan_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        irq, dma_req;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    scan_seq_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq), .dma_req(dma_req));

    // converter model, monitors
    logic [4:0] log_ch [64];
    int  nlog = 0, dma_cnt = 0, proto_err = 0;
    bit  busy = 0, hold = 0, prev_start = 0;
    int  wcnt = 0;
    logic [4:0] cur_ch;

    function automatic logic [11:0] raw_of(input logic [4:0] ch);
        return 12'((int'(ch) * 131 + 2730) % 4096);
    endfunction

    function automatic logic [4:0] chan_of(input logic [4:0] base, input int k);
        return 5'((int'(base) + 7 * k) % 32);
    endfunction

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (dma_req) dma_cnt++;
        if (conv_start && prev_start) proto_err++;
        prev_start = conv_start;
        if (busy) begin
            if (wcnt > 0) wcnt--;
            else if (!hold) begin
                conv_done = 1'b1;
                conv_result = raw_of(cur_ch);
                busy = 0;
            end
        end
        if (conv_start) begin
            if (busy) proto_err++;
            busy = 1; wcnt = 4; cur_ch = conv_chan;
            if (nlog < 64) log_ch[nlog] = conv_chan;
            nlog++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_slots(input logic [4:0] base, input logic [3:0] len);
        logic [31:0] w [3];
        w[0] = '0; w[1] = '0; w[2] = '0;
        for (int k = 0; k < 16; k++) w[k / 6][5 * (k % 6) +: 5] = chan_of(base, k);
        w[2][23:20] = len;
        wr(3'd5, w[0]); wr(3'd4, w[1]); wr(3'd3, w[2]);
    endtask

    task automatic wait_eoc(output bit seen);
        logic [31:0] s;
        seen = 0;
        for (int p = 0; p < 60 && !seen; p++) begin
            rd(3'd0, s);
            seen = s[1];
        end
    endtask

    // starts a sequence and reads back every result
    task automatic run_seq(input int n, input logic [1:0] res, input logic [4:0] base);
        logic [31:0] d;
        bit seen;
        wr(3'd0, 32'h0);
        nlog = 0;
        wr(3'd2, 32'h4000_0001);
        for (int i = 0; i < n; i++) begin
            wait_eoc(seen);
            check("R5 eoc raised", 32'(seen), 32'd1);
            rd(3'd6, d);
            check("R4 data", d, 32'(raw_of(chan_of(base, i)) >> (2 * res)));
            check("R2 slot order", 32'(log_ch[i]), 32'(chan_of(base, i)));
        end
        idle(20);
        check("R3 conversion count", 32'(nlog), 32'(n));
        rd(3'd0, d);
        check("R5 started set, eoc cleared by data read", d & 32'h12, 32'h10);
    endtask

    localparam logic [11:0] VEC [4] = '{
        {1'b1, 2'd0, 4'd15, 5'd3},
        {1'b1, 2'd1, 4'd2,  5'd20},
        {1'b0, 2'd2, 4'd5,  5'd9},
        {1'b1, 2'd3, 4'd0,  5'd30}
    };

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit seen;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd(3'd0, d); check("R1 status", d, 0);
        rd(3'd2, d); check("R1 ctrl2", d, 0);
        rd(3'd6, d); check("R1 data", d, 0);
        check("R1 outputs", {29'd0, irq, dma_req, conv_start}, 0);

        // vector table: scan, resolution, length, channel base
        for (int v = 0; v < 4; v++) begin
            logic sc; logic [1:0] rs; logic [3:0] ln; logic [4:0] bs;
            {sc, rs, ln, bs} = VEC[v];
            wr(3'd1, (32'(rs) << 24) | (32'(sc) << 8));
            program_slots(bs, ln);
            run_seq(sc ? int'(ln) + 1 : 1, rs, bs);
        end

        // R7 start bit self-clears after use
        rd(3'd2, d); check("R7 start self-clear", d & 32'h4000_0000, 0);

        // R7 start ignored with trigger mode set or power off
        nlog = 0;
        wr(3'd2, 32'h5000_0001); idle(15);
        check("R7 trig mode blocks start", 32'(nlog), 0);
        rd(3'd2, d); check("R7 start reads zero", d & 32'h4000_0000, 0);
        wr(3'd2, 32'h4000_0000); idle(15);
        check("R7 unpowered start ignored", 32'(nlog), 0);

        // R6 interrupt follows eoc and enable
        wr(3'd1, 32'h20);
        program_slots(5'd11, 4'd0);
        wr(3'd0, 0);
        wr(3'd2, 32'h4000_0001);
        wait_eoc(seen);
        check("R6 irq raised", 32'(irq), 1);
        rd(3'd6, d);
        check("R6 irq dropped after data read", 32'(irq), 0);
        // R5 status write-zero clear
        wr(3'd2, 32'h4000_0001);
        wait_eoc(seen);
        wr(3'd0, 32'hFFFF_FFFD);
        rd(3'd0, d); check("R5 write-one keeps started", d & 32'h10, 32'h10);
        check("R5 write-zero clears eoc", d & 32'h2, 0);

        // R8 overrun: two results, none read
        wr(3'd1, 32'h100);
        program_slots(5'd17, 4'd1);
        wr(3'd0, 0);
        wr(3'd2, 32'h4000_0001);
        idle(40);
        rd(3'd0, d); check("R8 overrun and eoc", d & 32'h22, 32'h22);
        rd(3'd6, d); check("R8 newer data kept", d, 32'(raw_of(chan_of(5'd17, 1))));
        wr(3'd0, 0);
        rd(3'd0, d); check("R8 overrun cleared", d & 32'h20, 0);

        // R9 DMA requests, halt and continuous
        program_slots(5'd4, 4'd2);
        dma_cnt = 0;
        wr(3'd2, 32'h4000_0101); idle(40);
        check("R9 one request per result", 32'(dma_cnt), 3);
        dma_cnt = 0;
        wr(3'd2, 32'h4000_0101); idle(40);
        check("R9 halted without continuous", 32'(dma_cnt), 0);
        wr(3'd2, 32'h1);
        dma_cnt = 0;
        wr(3'd2, 32'h4000_0301); idle(40);
        wr(3'd2, 32'h4000_0301); idle(40);
        check("R9 continuous across sequences", 32'(dma_cnt), 6);

        // R10 abort with a held conversion
        wr(3'd2, 32'h1);
        program_slots(5'd6, 4'd3);
        wr(3'd0, 0);
        hold = 1; nlog = 0;
        wr(3'd2, 32'h4000_0001);
        for (int t = 0; t < 20 && nlog == 0; t++) idle(1);
        idle(5);
        wr(3'd2, 32'h0);
        hold = 0;
        idle(20);
        check("R10 no start after abort", 32'(nlog), 1);
        rd(3'd0, d); check("R10 late done ignored", d & 32'h2, 0);
        run_seq(4, 2'd0, 5'd6);
        check("R11 start pulse protocol", 32'(proto_err), 0);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule